// File: doc/BRIEF.md
# Four-Terminal Switching Lattice Evaluator

This block evaluates a rectangular grid of four-terminal switches. Every cell is configured to follow one input variable, the complement of one input variable, a constant 0 or a constant 1. A cell whose resolved value is 1 joins all four of its neighbours' terminals; a cell at 0 isolates them. The block reports whether a chain of conducting cells, moving only horizontally and vertically, links the upper edge of the grid to the lower edge.

A start pulse captures the input variables and the per-cell configuration, and resolves every cell. It then seeds a reach set with the conducting cells of the first row. On each following clock the set grows by every conducting cell that touches a reached cell on one of its four sides. The sweep stops as soon as a clock adds nothing. The result is then taken from the last row.

A second sweep runs at the same time over the non-conducting cells, with diagonal moves allowed. It is seeded from the first column and judged on the last column. This gives the dual left-to-right result, which must always be the inverse of the main one. The block is used as a reconfigurable logic element: software-free configuration bits select the literals, and the two results are read on the done pulse.

Top module: `lattice_eval`

## Requirements
- R1: Each cell has a 2-bit mode and a variable index. Mode 0 takes the indexed input variable and mode 1 takes its complement. Mode 2 forces the cell to 0 and mode 3 forces it to 1. An index at or above the variable count reads as 0.
- R2: Cell (row r, column c) has index r*COLS+c, and row 0 is the upper edge. `topBottom` is 1 exactly when a chain of resolved-1 cells, each sharing a side with the next, joins some row-0 cell to some last-row cell. On a 3×3 grid this equals the OR of the nine path products {0,3,6}, {1,4,7}, {2,5,8}, {0,3,4,7}, {1,4,3,6}, {1,4,5,8}, {2,5,4,7}, {0,3,4,5,8} and {2,5,4,3,6}. Whenever it is 1, every row holds a 1 cell, and every two adjacent rows hold a 1 cell in the same column.
- R3: Cells that touch only at a corner do not conduct into one another for `topBottom`.
- R4: `leftRight` is 1 exactly when a chain of resolved-0 cells joins column 0 to the last column. In this chain, consecutive cells may share a side or a corner.
- R5: On every completion, `leftRight` equals the inverse of `topBottom`.
- R6: A start while idle raises `busy` on the next clock. `done` is a single-cycle pulse issued with `busy` low. Both results update only together with `done` and hold until the next `done`.
- R7: `done` appears no more than ROWS*COLS+1 clocks after the clock that accepted the start.
- R8: While `busy` is high, changes on the variables or the configuration, and further start pulses, have no effect on the result. They also do not trigger a second evaluation.
- R9: After reset, `busy`, `done`, `topBottom` and `leftRight` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an evaluation when idle |
| varsIn | input | NVARS | Input variable vector |
| cellModeIn | input | 2*ROWS*COLS | Per-cell mode, cell i at bits [2i+1:2i] |
| cellVarIn | input | VIW*ROWS*COLS | Per-cell variable index, cell i at bits [VIW*i +: VIW] |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle completion pulse |
| topBottom | output | 1 | Four-connected top-to-bottom result |
| leftRight | output | 1 | Eight-connected left-to-right dual result |

## Verification
The assertions assume that `start` may arrive in any cycle. They also assume that every variable index names an existing input, and that both reach sets stop growing within ROWS*COLS-1 steps. The stimulus draws indices only below the variable count. It applies configuration changes and extra starts while busy only after the start has been accepted. The expected results come from enumerated path products rather than a flood model. This lets the duality and convergence properties be checked against an independent reading of the grid.

// File: rtl/lattice_pkg.sv
package lattice_pkg;

  typedef enum logic [1:0] {
    MODE_TRUE = 2'd0,
    MODE_INV  = 2'd1,
    MODE_LOW  = 2'd2,
    MODE_HIGH = 2'd3
  } cellMode_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } sweepState_e;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } ctrlStrobe_t;

endpackage

// File: rtl/lattice_datapath.sv
module lattice_datapath
  import lattice_pkg::*;
#(
  parameter int ROWS  = 3,
  parameter int COLS  = 3,
  parameter int NVARS = 4,
  parameter int VIW   = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strb,
  input  logic [NVARS-1:0]          varsIn,
  input  logic [2*ROWS*COLS-1:0]    cellModeIn,
  input  logic [VIW*ROWS*COLS-1:0]  cellVarIn,
  output logic                      grew,
  output logic                      topBottom,
  output logic                      leftRight
);

  localparam int CELLS = ROWS * COLS;
  localparam int LAST_ROW = (ROWS - 1) * COLS;

  logic [CELLS-1:0] cellNow;
  logic [CELLS-1:0] cellOn;
  logic [CELLS-1:0] reachTB;
  logic [CELLS-1:0] reachLR;
  logic [CELLS-1:0] tbNext;
  logic [CELLS-1:0] lrNext;
  logic [CELLS-1:0] tbSeed;
  logic [CELLS-1:0] lrSeed;
  logic             tbHit;
  logic             lrHit;

  logic [ROWS+1:0][COLS+1:0] tbPad;
  logic [ROWS+1:0][COLS+1:0] lrPad;

  // Per-cell literal resolution.
  for (genvar i = 0; i < CELLS; i++) begin : g_resolve
    logic [1:0]     modeBits;
    logic [VIW-1:0] varIdx;
    logic           litVal;
    logic           onBit;

    assign modeBits = cellModeIn[2*i +: 2];
    assign varIdx   = cellVarIn[VIW*i +: VIW];

    always_comb begin
      litVal = 1'b0;
      for (int k = 0; k < NVARS; k++) begin
        if (varIdx == VIW'(k)) litVal = varsIn[k];
      end
    end

    always_comb begin
      case (cellMode_e'(modeBits))
        MODE_TRUE: onBit = litVal;
        MODE_INV:  onBit = ~litVal;
        MODE_LOW:  onBit = 1'b0;
        default:   onBit = 1'b1;
      endcase
    end

    assign cellNow[i] = onBit;
  end

  // Seeds: conducting cells of the upper row, isolating cells of the left column.
  always_comb begin
    tbSeed = '0;
    lrSeed = '0;
    for (int c = 0; c < COLS; c++) tbSeed[c] = cellNow[c];
    for (int r = 0; r < ROWS; r++) lrSeed[r*COLS] = ~cellNow[r*COLS];
  end

  // Zero-bordered copies of the reach sets so every neighbour index is legal.
  always_comb begin
    tbPad = '0;
    lrPad = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        tbPad[r+1][c+1] = reachTB[r*COLS+c];
        lrPad[r+1][c+1] = reachLR[r*COLS+c];
      end
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;

      assign tbNext[IDX] = cellOn[IDX] &
        (tbPad[r+1][c+1] | tbPad[r][c+1] | tbPad[r+2][c+1] |
         tbPad[r+1][c]   | tbPad[r+1][c+2]);

      assign lrNext[IDX] = ~cellOn[IDX] &
        (|{lrPad[r][c],   lrPad[r][c+1],   lrPad[r][c+2],
           lrPad[r+1][c], lrPad[r+1][c+1], lrPad[r+1][c+2],
           lrPad[r+2][c], lrPad[r+2][c+1], lrPad[r+2][c+2]});
    end
  end

  always_comb begin
    tbHit = 1'b0;
    lrHit = 1'b0;
    for (int c = 0; c < COLS; c++) tbHit |= reachTB[LAST_ROW + c];
    for (int r = 0; r < ROWS; r++) lrHit |= reachLR[r*COLS + COLS - 1];
  end

  assign grew = (tbNext != reachTB) || (lrNext != reachLR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cellOn    <= '0;
      reachTB   <= '0;
      reachLR   <= '0;
      topBottom <= 1'b0;
      leftRight <= 1'b0;
    end else begin
      if (strb.load) begin
        cellOn  <= cellNow;
        reachTB <= tbSeed;
        reachLR <= lrSeed;
      end else if (strb.step) begin
        reachTB <= tbNext;
        reachLR <= lrNext;
      end
      if (strb.finish) begin
        topBottom <= tbHit;
        leftRight <= lrHit;
      end
    end
  end

  // R2: a reached conducting cell is never dropped by a sweep step.
  assert_tb_monotone_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> ((reachTB & $past(reachTB)) == $past(reachTB)));

  // R4: the dual reach set only grows as well.
  assert_lr_monotone_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> ((reachLR & $past(reachLR)) == $past(reachLR)));

  // R7: the controller ends a sweep only once both sets have settled.
  assert_converged_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |-> !grew);

  // R8: the captured cell vector is untouched while a sweep runs.
  assert_capture_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step || strb.finish) |=> $stable(cellOn));

endmodule

// File: rtl/lattice_ctrl.sv
module lattice_ctrl
  import lattice_pkg::*;
#(
  parameter int CELLS = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        grew,
  output ctrlStrobe_t strb,
  output logic        busy,
  output logic        done
);

  localparam int CW = $clog2(CELLS + 1);

  sweepState_e   state;
  logic [CW-1:0] stepCnt;
  logic          limit;

  assign limit = (stepCnt == CW'(CELLS - 1));
  assign busy  = (state == ST_SWEEP);

  always_comb begin
    strb        = '0;
    strb.load   = (state == ST_IDLE) && start;
    strb.step   = (state == ST_SWEEP) && grew && !limit;
    strb.finish = (state == ST_SWEEP) && (!grew || limit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strb.finish;
      if (strb.load) begin
        state   <= ST_SWEEP;
        stepCnt <= '0;
      end else if (strb.step) begin
        stepCnt <= stepCnt + 1'b1;
      end else if (strb.finish) begin
        state <= ST_IDLE;
      end
    end
  end

  // R6: an accepted start shows up as busy one clock later.
  assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R6: done lasts exactly one clock.
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: completion is reported only when the sweep has ended.
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/lattice_eval.sv
module lattice_eval
  import lattice_pkg::*;
#(
  parameter int ROWS  = 3,
  parameter int COLS  = 3,
  parameter int NVARS = 4,
  parameter int VIW   = (NVARS > 1) ? $clog2(NVARS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [NVARS-1:0]          varsIn,
  input  logic [2*ROWS*COLS-1:0]    cellModeIn,
  input  logic [VIW*ROWS*COLS-1:0]  cellVarIn,
  output logic                      busy,
  output logic                      done,
  output logic                      topBottom,
  output logic                      leftRight
);

  localparam int CELLS = ROWS * COLS;

  ctrlStrobe_t strb;
  logic        grew;

  lattice_ctrl #(
    .CELLS(CELLS)
  ) i_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .grew (grew),
    .strb (strb),
    .busy (busy),
    .done (done)
  );

  lattice_datapath #(
    .ROWS (ROWS),
    .COLS (COLS),
    .NVARS(NVARS),
    .VIW  (VIW)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .varsIn    (varsIn),
    .cellModeIn(cellModeIn),
    .cellVarIn (cellVarIn),
    .grew      (grew),
    .topBottom (topBottom),
    .leftRight (leftRight)
  );

  // R5: the two sweeps always disagree on completion.
  assert_duality_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (leftRight != topBottom));

  // R6: results move only together with the done pulse.
  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(topBottom) && $stable(leftRight)));

endmodule

// File: tb/test_lattice_eval.sv
module test_lattice_eval;

  localparam int ROWS  = 3;
  localparam int COLS  = 3;
  localparam int NVARS = 4;
  localparam int VIW   = 2;
  localparam int CELLS = ROWS * COLS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [NVARS-1:0] varsIn = '0;
  logic [2*CELLS-1:0] cellModeIn = '0;
  logic [VIW*CELLS-1:0] cellVarIn = '0;
  logic busy, done, topBottom, leftRight;

  always #5 clk = ~clk;

  lattice_eval #(
    .ROWS(ROWS), .COLS(COLS), .NVARS(NVARS), .VIW(VIW)
  ) i_lattice_eval (
    .clk(clk), .rstN(rstN), .start(start), .varsIn(varsIn),
    .cellModeIn(cellModeIn), .cellVarIn(cellVarIn),
    .busy(busy), .done(done), .topBottom(topBottom), .leftRight(leftRight)
  );

  typedef struct packed {
    logic       tb;
    logic       lr;
    logic [8:0] on;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails = 0;

  // Vertical side-connected paths and left-right corner-connected paths of a 3x3 grid.
  localparam logic [8:0] TB_MASKS [9] = '{9'h049, 9'h092, 9'h124, 9'h099, 9'h05A,
                                          9'h132, 9'h0B4, 9'h139, 9'h07C};
  localparam logic [8:0] LR_MASKS [17] = '{9'd7, 9'd35, 9'd21, 9'd49, 9'd273, 9'd14,
                                           9'd42, 9'd28, 9'd56, 9'd280, 9'd168, 9'd392,
                                           9'd84, 9'd112, 9'd336, 9'd224, 9'd448};

  function automatic logic [8:0] resolveCells(input logic [17:0] md, input logic [17:0] vx,
                                              input logic [3:0] x);
    logic [8:0] r;
    for (int i = 0; i < 9; i++) begin
      case (md[2*i +: 2])
        2'd0:    r[i] = x[vx[2*i +: 2]];
        2'd1:    r[i] = ~x[vx[2*i +: 2]];
        2'd2:    r[i] = 1'b0;
        default: r[i] = 1'b1;
      endcase
    end
    return r;
  endfunction

  function automatic logic tbModel(input logic [8:0] on);
    for (int k = 0; k < 9; k++) if ((on & TB_MASKS[k]) == TB_MASKS[k]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic lrModel(input logic [8:0] on);
    logic [8:0] off;
    off = ~on;
    for (int k = 0; k < 17; k++) if ((off & LR_MASKS[k]) == LR_MASKS[k]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic rowsOk(input logic [8:0] on);
    for (int r = 0; r < 3; r++) if (((on >> (3*r)) & 9'd7) == 9'd0) return 1'b0;
    for (int r = 0; r < 2; r++)
      if ((((on >> (3*r)) & 9'd7) & ((on >> (3*r+3)) & 9'd7)) == 9'd0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [17:0] constCfg(input logic [8:0] on);
    logic [17:0] m;
    for (int i = 0; i < 9; i++) m[2*i +: 2] = on[i] ? 2'd3 : 2'd2;
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // Monitor: pops one expected item per completion.
  always @(negedge clk) begin
    expItem_t e;
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6", "done without start", 1, 0);
      end else begin
        e = expQ.pop_front();
        check(topBottom == e.tb, "R2", "topBottom", topBottom, e.tb);
        check(leftRight == e.lr, "R4", "leftRight", leftRight, e.lr);
        check(leftRight != topBottom, "R5", "duality", leftRight, !topBottom);
        if (topBottom) check(rowsOk(e.on), "R2", "row conditions", 0, 1);
      end
    end
  end

  // Driver: pushes the expectation, pulses start, waits for completion.
  task automatic runVector(input logic [17:0] md, input logic [17:0] vx,
                           input logic [3:0] x, input bit disturb);
    expItem_t e;
    int cnt;
    e.on = resolveCells(md, vx, x);
    e.tb = tbModel(e.on);
    e.lr = lrModel(e.on);
    expQ.push_back(e);
    @(negedge clk);
    cellModeIn = md; cellVarIn = vx; varsIn = x; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R6", "busy after start", busy, 1);
    if (disturb) begin
      cellModeIn = ~md; cellVarIn = ~vx; varsIn = ~x; start = 1'b1;
    end
    cnt = 1;
    while (!done && cnt < 4*CELLS) begin
      @(negedge clk);
      start = 1'b0;
      cnt++;
    end
    check(done == 1'b1 && cnt <= CELLS + 1, "R7", "cycles to done", cnt, CELLS + 1);
    check(busy == 1'b0, "R6", "busy during done", busy, 0);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, disturb ? "R8" : "R6", "idle after done",
          int'({done, busy}), 0);
    check(topBottom == e.tb, disturb ? "R8" : "R6", "result held", topBottom, e.tb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual 0 expected 1 completion");
    summary();
    $finish;
  end

  initial begin
    logic [17:0] md, vx;
    // R9: reset state, during and right after reset.
    repeat (3) @(negedge clk);
    check({busy, done, topBottom, leftRight} == 4'b0, "R9", "outputs in reset",
          int'({busy, done, topBottom, leftRight}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, done, topBottom, leftRight} == 4'b0, "R9", "outputs after reset",
          int'({busy, done, topBottom, leftRight}), 0);

    // R1: column 1 follows variable 2, true then complemented.
    md = constCfg(9'h000);
    vx = '0;
    for (int r = 0; r < 3; r++) begin
      md[2*(3*r+1) +: 2] = 2'd0;
      vx[2*(3*r+1) +: 2] = 2'd2;
    end
    runVector(md, vx, 4'b0100, 1'b0);
    check(topBottom == 1'b1, "R1", "true literal high", topBottom, 1);
    runVector(md, vx, 4'b1011, 1'b0);
    check(topBottom == 1'b0, "R1", "true literal low", topBottom, 0);
    for (int r = 0; r < 3; r++) md[2*(3*r+1) +: 2] = 2'd1;
    runVector(md, vx, 4'b1011, 1'b0);
    check(topBottom == 1'b1, "R1", "complement literal", topBottom, 1);
    runVector(md, vx, 4'b0100, 1'b0);
    check(topBottom == 1'b0, "R1", "complement literal low", topBottom, 0);

    // R2: each of the nine paths alone conducts.
    for (int k = 0; k < 9; k++) begin
      runVector(constCfg(TB_MASKS[k]), '0, 4'h0, 1'b0);
      check(topBottom == 1'b1, "R2", "single path", topBottom, 1);
    end

    // R3: corner-only contacts do not conduct.
    runVector(constCfg(9'h111), '0, 4'h0, 1'b0);
    check(topBottom == 1'b0, "R3", "main diagonal", topBottom, 0);
    runVector(constCfg(9'h054), '0, 4'h0, 1'b0);
    check(topBottom == 1'b0, "R3", "anti diagonal", topBottom, 0);
    runVector(constCfg(9'h0AA), '0, 4'h0, 1'b0);
    check(topBottom == 1'b0, "R3", "diamond", topBottom, 0);

    // R2, R4, R5: every constant pattern.
    for (int p = 0; p < 512; p++) runVector(constCfg(9'(p)), '0, 4'(p), 1'b0);

    // R1, R2, R4: random literal configurations.
    for (int n = 0; n < 200; n++)
      runVector(18'($urandom()), 18'($urandom()), 4'($urandom()), 1'b0);

    // R8: inputs and start toggled while busy.
    for (int n = 0; n < 20; n++)
      runVector(18'($urandom()), 18'($urandom()), 4'($urandom()), 1'b1);

    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R6", "pending results", expQ.size(), 0);
    summary();
    $finish;
  end

endmodule